// File: doc/BRIEF.md
# Program Counter Sequencer with Conditional Skip and Return Stack

This block produces the fetch address of a small 8-bit microcontroller core with a 13-bit program space. On every clock it advances the program counter by one, unless the instruction now executing is a call, a return or a taken bit-test skip. Each of those three costs one extra cycle, because the word already fetched behind it must not run. The block raises a flush output for that cycle. Decode logic downstream uses flush to turn the fetched word into a no-op.

A call saves its return address in an eight-entry circular hardware stack. It then jumps to a target built from two parts: the low eleven bits come from the instruction's immediate field, and the top two bits come from bits 4:3 of a separate page-latch register. A return pops the newest stack entry back into the counter. The instruction class arrives already decoded. The skip condition is one bit supplied by the register file.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset sets fetch_addr to 0, drops flush, zeroes all eight stack entries and points the stack at its first slot.
- R2: With op = 2'b00 (sequential) and flush low, fetch_addr becomes fetch_addr+1 on the next clock, wrapping 0x1FFF to 0x0000, and flush is low.
- R3: With op = 2'b01 (bit-test skip) and skip_bit = 0, the block behaves exactly as a sequential step.
- R4: With op = 2'b01 and skip_bit = 1, fetch_addr increments and flush is high for the following cycle.
- R5: While flush is high, op, imm, page_latch and skip_bit have no effect: the stack is unchanged, fetch_addr increments and flush falls on the next clock.
- R6: With op = 2'b10 (call), the next fetch_addr has bits 10:0 equal to imm and bits 12:11 equal to page_latch[4:3], and flush is high for that cycle.
- R7: A call pushes the fetch_addr present while it executes, which is the call's own address plus one, as the return address.
- R8: With op = 2'b11 (return), fetch_addr loads the most recently pushed, not yet popped entry, that entry is popped, and flush is high for that cycle.
- R9: The stack is eight entries deep and circular. A ninth push overwrites the oldest entry, and pops past the bottom wrap around to the top entry without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Decoded class: 00 sequential, 01 bit-test skip, 10 call, 11 return |
| imm | input | 11 | Call target, low bits |
| page_latch | input | 8 | Page-latch register; bits 4:3 supply the call target's upper bits |
| skip_bit | input | 1 | Value of the tested register bit |
| fetch_addr | output | 13 | Program counter, the address to fetch |
| flush | output | 1 | The word fetched this cycle must execute as a no-op |

## Verification
The hardest state to reach from the ports is a stack that has wrapped. Getting there takes more than eight nested calls with no return between them, and every call adds a flush cycle that blocks the next call. The stimulus issues ten back-to-back calls to distinct targets, then ten returns. The returned addresses show which entries were overwritten and how pops wrap below the bottom. A call that lands on address 0x1FFF, followed by a sequential step, covers the counter wraparound. Long random runs also drive calls, returns and skips during flush cycles, to show that those cycles ignore their inputs.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int PC_W    = 13,
  parameter int IMM_W   = 11,
  parameter int DEPTH   = 8,
  parameter int LATCH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         op,
  input  logic [IMM_W-1:0]   imm,
  input  logic [LATCH_W-1:0] page_latch,
  input  logic               skip_bit,
  output logic [PC_W-1:0]    fetch_addr,
  output logic               flush
);
  localparam int SP_W   = $clog2(DEPTH);
  localparam int HI_W   = PC_W - IMM_W;
  localparam int PAGE_LO = IMM_W - 8;

  localparam logic [1:0] OP_SEQ  = 2'b00;
  localparam logic [1:0] OP_SKIP = 2'b01;
  localparam logic [1:0] OP_CALL = 2'b10;
  localparam logic [1:0] OP_RET  = 2'b11;

  logic [PC_W-1:0] pc;
  logic            nop_q;
  logic [SP_W-1:0] sp;
  logic [PC_W-1:0] stk [DEPTH];

  wire [SP_W-1:0] sp_dn    = sp - 1'b1;
  wire [PC_W-1:0] call_tgt = {page_latch[PAGE_LO +: HI_W], imm};
  wire [PC_W-1:0] pc_inc   = pc + 1'b1;
  wire            live     = !nop_q;

  assign fetch_addr = pc;
  assign flush      = nop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      nop_q <= 1'b0;
      sp    <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      pc    <= pc_inc;
      nop_q <= 1'b0;
      if (live) begin
        case (op)
          OP_SKIP: nop_q <= skip_bit;
          OP_CALL: begin
            stk[sp] <= pc;
            sp      <= sp + 1'b1;
            pc      <= call_tgt;
            nop_q   <= 1'b1;
          end
          OP_RET: begin
            sp    <= sp_dn;
            pc    <= stk[sp_dn];
            nop_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (fetch_addr == '0 && !flush));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op == OP_SEQ) |=> (fetch_addr == $past(fetch_addr) + 1'b1 && !flush));

  // R3
  skip_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op == OP_SKIP && !skip_bit) |=> !flush);

  // R4
  skip_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op == OP_SKIP && skip_bit) |=> (flush && fetch_addr == $past(fetch_addr) + 1'b1));

  // R5
  flush_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!flush && fetch_addr == $past(fetch_addr) + 1'b1));

  // R6
  call_target_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op == OP_CALL) |=>
      (flush && fetch_addr[IMM_W-1:0] == $past(imm)
             && fetch_addr[PC_W-1:IMM_W] == $past(page_latch[PAGE_LO +: HI_W])));

  // R8
  ret_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush && op == OP_RET) |=> flush);
endmodule

// File: tb/sim_pc_sequencer.sv
module sim_pc_sequencer;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op = 2'b00;
  logic [10:0] imm = '0;
  logic [7:0]  page_latch = '0;
  logic        skip_bit = 1'b0;
  logic [12:0] fetch_addr;
  logic        flush;

  int checks = 0;
  int fails  = 0;

  int m_pc, m_flush, m_sp;
  int m_stk [8];
  string tag;

  pc_sequencer u0 (.clk(clk), .rst(rst), .op(op), .imm(imm), .page_latch(page_latch),
                   .skip_bit(skip_bit), .fetch_addr(fetch_addr), .flush(flush));

  always #(PERIOD/2) clk = ~clk;

  task automatic compare();
    checks++;
    if (fetch_addr !== 13'(m_pc) || flush !== 1'(m_flush)) begin
      fails++;
      $display("FAIL %s: fetch_addr=%h flush=%b expected fetch_addr=%h flush=%0d",
               tag, fetch_addr, flush, 13'(m_pc), m_flush);
    end
  endtask

  // One instruction cycle: drive at negedge, model next state, check at the next negedge.
  task automatic step(input logic [1:0] o, input logic [10:0] k, input logic [7:0] pl, input logic sb);
    int was_flush;
    op = o; imm = k; page_latch = pl; skip_bit = sb;
    was_flush = m_flush;
    m_flush = 0;
    if (was_flush) begin
      tag = "R5"; m_pc = (m_pc + 1) % 8192;
    end else begin
      case (o)
        2'b00: begin tag = "R2"; m_pc = (m_pc + 1) % 8192; end
        2'b01: begin
          tag = sb ? "R4" : "R3";
          m_pc = (m_pc + 1) % 8192;
          m_flush = sb;
        end
        2'b10: begin
          tag = "R6/R7";
          m_stk[m_sp] = m_pc;
          m_sp = (m_sp + 1) % 8;
          m_pc = ((int'(pl) >> 3) % 4) * 2048 + int'(k);
          m_flush = 1;
        end
        default: begin
          tag = "R8/R9";
          m_sp = (m_sp + 7) % 8;
          m_pc = m_stk[m_sp];
          m_flush = 1;
        end
      endcase
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    m_pc = 0; m_flush = 0; m_sp = 0;
    for (int i = 0; i < 8; i++) m_stk[i] = 0;
    tag = "R1";
    compare();
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1: a return straight after reset pops a zeroed entry
    step(2'b11, 11'h0, 8'h0, 1'b0);
    step(2'b00, 11'h0, 8'h0, 1'b0);
    for (int i = 0; i < 4; i++) step(2'b00, 11'h0, 8'h0, 1'b0);
    // R3, R4
    step(2'b01, 11'h0, 8'h0, 1'b0);
    step(2'b01, 11'h0, 8'h0, 1'b1);
    // R5: call issued during flush is ignored
    step(2'b10, 11'h155, 8'hFF, 1'b1);
    step(2'b00, 11'h0, 8'h0, 1'b0);
    // R6 + R2 wrap: call to 0x1FFF then sequential
    step(2'b10, 11'h7FF, 8'h18, 1'b0);
    step(2'b00, 11'h0, 8'h0, 1'b0);
    step(2'b00, 11'h0, 8'h0, 1'b0);
    step(2'b00, 11'h0, 8'h0, 1'b0);
    // R6: page bits outside 4:3 do not matter
    step(2'b10, 11'h123, 8'hE7, 1'b0);
    step(2'b00, 11'h0, 8'h0, 1'b0);
    // R7, R8: return lands after the call
    step(2'b11, 11'h0, 8'h0, 1'b0);
    step(2'b00, 11'h0, 8'h0, 1'b0);
    // R9: ten nested calls then ten returns
    for (int i = 0; i < 10; i++) begin
      step(2'b10, 11'(i * 100 + 7), 8'((i % 4) << 3), 1'b0);
      step(2'b00, 11'h0, 8'h0, 1'b0);
    end
    for (int i = 0; i < 10; i++) begin
      step(2'b11, 11'h0, 8'h0, 1'b0);
      step(2'b00, 11'h0, 8'h0, 1'b0);
    end
    // random mix, including inputs during flush
    for (int i = 0; i < 3000; i++)
      step(2'($urandom), 11'($urandom), 8'($urandom), 1'($urandom));
    do_reset();
    for (int i = 0; i < 200; i++)
      step(2'($urandom), 11'($urandom), 8'($urandom), 1'($urandom));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule